// File: doc/BRIEF.md
# Windowed Supervision Watchdog

This block watches a host processor and decides whether it is still alive. The host proves it is running by sending single-cycle write strobes. Each strobe must land inside a time window set by a lower and an upper count bound. A strobe that comes too early is a violation. So is a missing strobe by the time the upper bound is reached. Each violation produces a one-cycle pulse and sets a sticky flag, which stays high until the host clears it.

Supervision does not begin with the window rule. The host must first give one proof of life, either a write strobe or a pulse on a dedicated keep-active pin, and it must do so before the upper bound expires. Only after that does the block report the initial condition as met and start enforcing the window. A global enable turns the whole function off. While disabled, the block reports the host as alive and never flags a violation. A suspend input, driven by the low-power mode, freezes supervision completely. When suspend is released, the counter restarts from zero and the initial proof of life is required again.

Top module: `win_watchdog`

## Requirements
- R1: After reset, with enable high, initAliveOk, violation, violationSticky and windowOpen are all low, and the counter starts from zero.
- R2: While initAliveOk is low, an aliveWr strobe seen at any count up to maxCount sets initAliveOk on the next cycle, restarts the counter and raises no violation.
- R3: While initAliveOk is low, a keepActive pulse has the same effect as aliveWr. Once initAliveOk is high, keepActive has no effect: it neither restarts the counter nor raises a violation.
- R4: With enable low, initAliveOk reads high and violation and windowOpen stay low, whatever the strobes do. When enable returns high, the counter starts from zero with initAliveOk low.
- R5: windowOpen is high exactly when enable is high, suspend is low, initAliveOk is high and the counter is at or above minCount. The counter advances by one each supervised cycle.
- R6: Once initAliveOk is high, an aliveWr seen with the counter anywhere from minCount to maxCount inclusive is accepted: there is no violation and the counter restarts from zero.
- R7: Once initAliveOk is high, an aliveWr seen with the counter below minCount raises violation on the next cycle and drops initAliveOk.
- R8: If the counter reaches maxCount with no accepted strobe, violation rises on the next cycle. This holds in the initial phase and in the supervised phase. The counter then restarts and initAliveOk is low.
- R9: violation is a one-cycle pulse. violationSticky is set together with it and stays high until a clearSticky strobe. A violation and a clear in the same cycle leave violationSticky set.
- R10: While suspend is high, the counter is held, aliveWr and keepActive are ignored, windowOpen is low and no violation occurs.
- R11: In the first cycle after suspend falls, the counter restarts from zero and initAliveOk goes low. A new proof of life is then needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global enable of the supervision |
| minCount | input | CNT_W | Lower bound of the write window |
| maxCount | input | CNT_W | Upper bound and timeout count |
| aliveWr | input | 1 | Host alive write strobe |
| keepActive | input | 1 | Alternative proof of life for the initial phase |
| suspend | input | 1 | Low-power suspend: freezes supervision |
| clearSticky | input | 1 | Clears violationSticky |
| initAliveOk | output | 1 | Initial proof of life received (high when disabled) |
| violation | output | 1 | One-cycle violation pulse |
| violationSticky | output | 1 | Latched violation flag |
| windowOpen | output | 1 | A write is currently allowed |

## Verification
Strobes are placed at counts 2, 3, 4 and 10 with minCount 4 and maxCount 10. This separates a write just below the window, the first legal count and the upper edge. Keep-active pulses are sent both before and after the proof of life, which shows that the pin counts in the initial phase and is ignored afterwards. Silent stretches of exactly maxCount cycles check the timeout in both phases. Early writes sent while disabled and while suspended show that these two states mask the rule, and the checks after suspend is released show the restart.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef struct packed {
    logic clr;
    logic inc;
  } wdStrobe_t;

  typedef struct packed {
    logic atMax;
    logic belowMin;
  } wdFlags_t;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_SLEEP,
    PH_WAKE,
    PH_INIT,
    PH_GUARD
  } wdPhase_t;
endpackage

// File: rtl/wd_count.sv
module wd_count #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wd_pkg::wdStrobe_t strb,
  input  logic [CNT_W-1:0]  minCount,
  input  logic [CNT_W-1:0]  maxCount,
  output wd_pkg::wdFlags_t  flags,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (strb.clr) count <= '0;
    else if (strb.inc) count <= count + ONE;
  end

  always_comb begin
    flags.atMax    = (count >= maxCount);
    flags.belowMin = (count < minCount);
  end

  AST_CLR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clr && strb.inc)); // R5
endmodule

// File: rtl/wd_ctrl.sv
module wd_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              suspend,
  input  logic              aliveWr,
  input  logic              keepActive,
  input  logic              clearSticky,
  input  wd_pkg::wdFlags_t  flags,
  output wd_pkg::wdStrobe_t strb,
  output logic              initAliveOk,
  output logic              violation,
  output logic              violationSticky,
  output logic              windowOpen
);
  import wd_pkg::*;

  wdPhase_t phase;
  logic aliveQ, suspendQ, violQ, stickyQ;
  logic aliveD, violD;

  always_comb begin
    if (!enable) phase = PH_OFF;
    else if (suspend) phase = PH_SLEEP;
    else if (suspendQ) phase = PH_WAKE;
    else if (!aliveQ) phase = PH_INIT;
    else phase = PH_GUARD;
  end

  always_comb begin
    strb   = '0;
    aliveD = aliveQ;
    violD  = 1'b0;
    case (phase)
      PH_OFF, PH_WAKE: begin
        strb.clr = 1'b1;
        aliveD   = 1'b0;
      end
      PH_SLEEP: begin
        strb = '0;
      end
      PH_INIT: begin
        if (aliveWr || keepActive) begin
          strb.clr = 1'b1;
          aliveD   = 1'b1;
        end else if (flags.atMax) begin
          strb.clr = 1'b1;
          violD    = 1'b1;
        end else begin
          strb.inc = 1'b1;
        end
      end
      default: begin
        if (aliveWr) begin
          strb.clr = 1'b1;
          if (flags.belowMin) begin
            violD  = 1'b1;
            aliveD = 1'b0;
          end
        end else if (flags.atMax) begin
          strb.clr = 1'b1;
          violD    = 1'b1;
          aliveD   = 1'b0;
        end else begin
          strb.inc = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aliveQ   <= 1'b0;
      suspendQ <= 1'b0;
      violQ    <= 1'b0;
      stickyQ  <= 1'b0;
    end else begin
      aliveQ   <= aliveD;
      suspendQ <= suspend;
      violQ    <= violD;
      if (violD) stickyQ <= 1'b1;
      else if (clearSticky) stickyQ <= 1'b0;
    end
  end

  assign initAliveOk     = !enable || aliveQ;
  assign violation       = violQ;
  assign violationSticky = stickyQ;
  assign windowOpen      = enable && !suspend && !suspendQ && aliveQ && !flags.belowMin;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !violation); // R4
  AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    suspend |=> !violation); // R10
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> violationSticky); // R9
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (violationSticky && !clearSticky) |=> violationSticky); // R9
  AST_WAKE_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $fell(suspend)) |=> !initAliveOk); // R11
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] minCount,
  input  logic [CNT_W-1:0] maxCount,
  input  logic             aliveWr,
  input  logic             keepActive,
  input  logic             suspend,
  input  logic             clearSticky,
  output logic             initAliveOk,
  output logic             violation,
  output logic             violationSticky,
  output logic             windowOpen
);
  import wd_pkg::*;

  wdStrobe_t        strb;
  wdFlags_t         flags;
  logic [CNT_W-1:0] count;

  wd_count #(.CNT_W(CNT_W)) uCount (
    .clk(clk), .rstN(rstN), .strb(strb),
    .minCount(minCount), .maxCount(maxCount),
    .flags(flags), .count(count)
  );

  wd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .suspend(suspend),
    .aliveWr(aliveWr), .keepActive(keepActive), .clearSticky(clearSticky),
    .flags(flags), .strb(strb), .initAliveOk(initAliveOk),
    .violation(violation), .violationSticky(violationSticky),
    .windowOpen(windowOpen)
  );

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && suspend) |=> $stable(count)); // R10
  AST_VIOL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (violation && maxCount != '0) |=> !violation); // R9
endmodule

// File: tb/tb_win_watchdog.sv
`timescale 1ns/1ps
module tb_win_watchdog;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN, enable, aliveWr, keepActive, suspend, clearSticky;
  logic [CNT_W-1:0] minCount, maxCount;
  logic initAliveOk, violation, violationSticky, windowOpen;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  win_watchdog #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .minCount(minCount),
    .maxCount(maxCount), .aliveWr(aliveWr), .keepActive(keepActive),
    .suspend(suspend), .clearSticky(clearSticky), .initAliveOk(initAliveOk),
    .violation(violation), .violationSticky(violationSticky),
    .windowOpen(windowOpen)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseWr();
    aliveWr = 1'b1; @(negedge clk); aliveWr = 1'b0;
  endtask

  task automatic pulseKeep();
    keepActive = 1'b1; @(negedge clk); keepActive = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; enable = 1'b1; aliveWr = 1'b0; keepActive = 1'b0;
    suspend = 1'b0; clearSticky = 1'b0; minCount = 16'd4; maxCount = 16'd10;
    waitCycles(2);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    #1;
    chk("R1", "initAliveOk", initAliveOk, 1'b0);
    chk("R1", "violation", violation, 1'b0);
    chk("R1", "sticky", violationSticky, 1'b0);
    chk("R1", "windowOpen", windowOpen, 1'b0);
  endtask

  task automatic testInitialWrite();
    waitCycles(3);
    pulseWr();
    chk("R2", "initAliveOk", initAliveOk, 1'b1);
    chk("R2", "violation", violation, 1'b0);
  endtask

  task automatic testWindow();
    waitCycles(3);
    chk("R5", "windowOpen at 3", windowOpen, 1'b0);
    waitCycles(1);
    chk("R5", "windowOpen at 4", windowOpen, 1'b1);
    pulseWr();
    chk("R6", "violation at min", violation, 1'b0);
    chk("R6", "restart closes window", windowOpen, 1'b0);
    waitCycles(10);
    pulseWr();
    chk("R6", "violation at max", violation, 1'b0);
    chk("R6", "still alive", initAliveOk, 1'b1);
  endtask

  task automatic testEarly();
    waitCycles(2);
    pulseWr();
    chk("R7", "violation", violation, 1'b1);
    chk("R7", "initAliveOk", initAliveOk, 1'b0);
    chk("R9", "sticky set", violationSticky, 1'b1);
    waitCycles(1);
    chk("R9", "pulse ends", violation, 1'b0);
    chk("R9", "sticky holds", violationSticky, 1'b1);
    clearSticky = 1'b1; @(negedge clk); clearSticky = 1'b0;
    chk("R9", "sticky cleared", violationSticky, 1'b0);
  endtask

  task automatic testKeep();
    doReset();
    pulseKeep();
    chk("R3", "keep sets alive", initAliveOk, 1'b1);
    waitCycles(2);
    pulseKeep();
    chk("R3", "keep later no violation", violation, 1'b0);
    waitCycles(1);
    chk("R3", "keep later no restart", windowOpen, 1'b1);
  endtask

  task automatic testTimeout();
    doReset();
    pulseWr();
    waitCycles(10);
    chk("R8", "no violation at max", violation, 1'b0);
    waitCycles(1);
    chk("R8", "guard timeout", violation, 1'b1);
    chk("R8", "alive dropped", initAliveOk, 1'b0);
    waitCycles(10);
    chk("R8", "initial no violation at max", violation, 1'b0);
    clearSticky = 1'b1; @(negedge clk); clearSticky = 1'b0;
    chk("R8", "initial timeout", violation, 1'b1);
    chk("R9", "set wins over clear", violationSticky, 1'b1);
  endtask

  task automatic testDisable();
    doReset();
    pulseWr();
    enable = 1'b0; #1;
    chk("R4", "initAliveOk disabled", initAliveOk, 1'b1);
    @(negedge clk);
    pulseWr();
    chk("R4", "no violation disabled", violation, 1'b0);
    chk("R4", "window closed disabled", windowOpen, 1'b0);
    waitCycles(15);
    chk("R4", "no timeout disabled", violation, 1'b0);
    enable = 1'b1;
    waitCycles(1);
    chk("R4", "rearm on enable", initAliveOk, 1'b0);
  endtask

  task automatic testSuspend();
    doReset();
    pulseWr();
    waitCycles(2);
    suspend = 1'b1;
    pulseWr();
    chk("R10", "early write ignored", violation, 1'b0);
    waitCycles(20);
    chk("R10", "no timeout", violation, 1'b0);
    chk("R10", "no sticky", violationSticky, 1'b0);
    chk("R10", "window closed", windowOpen, 1'b0);
    suspend = 1'b0;
    waitCycles(1);
    chk("R11", "rearm after wake", initAliveOk, 1'b0);
    pulseWr();
    chk("R11", "alive again", initAliveOk, 1'b1);
    waitCycles(3);
    chk("R11", "restarted count 3", windowOpen, 1'b0);
    waitCycles(1);
    chk("R11", "restarted count 4", windowOpen, 1'b1);
  endtask

  initial begin
    testReset();
    testInitialWrite();
    testWindow();
    testEarly();
    testKeep();
    testTimeout();
    testDisable();
    testSuspend();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule